// File: doc/BRIEF.md
# Tape trailer checksum generator

This block forms the 6-bit checksum that a tape block carries in its trailer. A start pulse opens a block and seeds a 12-bit accumulator with all ones. Each data word that follows is folded in by XOR with the word's complement. The block closes after a set number of words, or earlier when a block-done pulse arrives. The 12-bit accumulator is then folded to 6 bits by XOR of its upper and lower halves.

The tape side then fetches the result one trailer line at a time, with one request per line. The first request returns the upper 3 bits of the checksum and the second returns the lower 3 bits. Every later request returns zero. The result and the done flag stay in place until the next start pulse, so the line requests can come at any pace.

Top module: `trailer_csum`

## Requirements
- R1: After reset, `doneOut` is 0 and `nibbleOut` is 0.
- R2: A start pulse sets the accumulator to 12'hFFF and the word count to zero. In the next cycle `doneOut` and `nibbleOut` read 0. This applies in every state, including in the middle of a block. A word presented in the same cycle as start is discarded.
- R3: While a block is open, each cycle with `wordValid` high replaces the accumulator with accumulator XOR (~`wordIn`), kept to 12 bits.
- R4: The checksum is accumulator[11:6] XOR accumulator[5:0], taken over every accepted word including the closing one.
- R5: `doneOut` rises in the cycle after the `BLOCK_WORDS`-th accepted word (default 129). It stays 0 before that unless R6 applies.
- R6: `blockDone` while a block is open closes it over the words received so far. A word valid in the same cycle is included. With no words, the checksum is 0.
- R7: Once `doneOut` is 1, each `nibbleReq` updates `nibbleOut` in the following cycle. The first request returns checksum bits [5:3], the second returns bits [2:0], and every later request returns 0.
- R8: While `doneOut` is 1, `wordValid` and `blockDone` have no effect. `doneOut` and the checksum hold until the next start pulse.
- R9: `nibbleReq` while `doneOut` is 0 leaves `nibbleOut` at 0 and does not use up a trailer line. Words arriving before any start pulse are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| startIn | input | 1 | Opens a new block |
| wordValid | input | 1 | `wordIn` holds a data word this cycle |
| wordIn | input | WORD_W (12) | Data word |
| blockDone | input | 1 | Closes the open block early |
| nibbleReq | input | 1 | Request for the next trailer line |
| nibbleOut | output | WORD_W/4 (3) | Trailer line value |
| doneOut | output | 1 | Checksum is complete and held |

## Verification
The bench builds the block with its defaults: 129 words per block and 12-bit words. With these values a full-length block completes in about 130 cycles, so the natural word-count close and the early `blockDone` close are both exercised. Single-word blocks with hand-computed checksums anchor the fold and the nibble order. Zero-word, restart-mid-block and start-with-word cases cover the boundaries.

// File: rtl/trailer_csum_pkg.sv
package trailer_csum_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACCUM = 2'd1,
    ST_DONE  = 2'd2
  } csState_e;

  localparam int LINE_W = 2;
  localparam logic [LINE_W-1:0] LAST_LINE = 2'd2;

  typedef struct packed {
    logic              initAcc;
    logic              foldWord;
    logic              capture;
    logic              emitNibble;
    logic [LINE_W-1:0] lineSel;
  } csStrobe_t;

endpackage

// File: rtl/trailer_csum_ctrl.sv
module trailer_csum_ctrl
  import trailer_csum_pkg::*;
#(
  parameter int BLOCK_WORDS = 129
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startIn,
  input  logic      wordValid,
  input  logic      blockDone,
  input  logic      nibbleReq,
  output csStrobe_t strobe,
  output logic      doneOut
);

  localparam int CNT_W = $clog2(BLOCK_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLOCK_WORDS - 1);

  csState_e          state, stateNext;
  logic [CNT_W-1:0]  wordCnt;
  logic [LINE_W-1:0] lineCnt;
  logic              lastWord;

  assign lastWord = wordValid && (wordCnt == LAST_IDX);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        if (startIn) strobe.initAcc = 1'b1;
      end
      ST_ACCUM: begin
        if (startIn) begin
          strobe.initAcc = 1'b1;
        end else begin
          strobe.foldWord = wordValid;
          strobe.capture  = lastWord || blockDone;
        end
      end
      ST_DONE: begin
        if (startIn) begin
          strobe.initAcc = 1'b1;
        end else if (nibbleReq) begin
          strobe.emitNibble = 1'b1;
          strobe.lineSel    = lineCnt;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    if (strobe.initAcc) stateNext = ST_ACCUM;
    else if (strobe.capture) stateNext = ST_DONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordCnt <= '0;
      lineCnt <= '0;
    end else begin
      state <= stateNext;
      if (strobe.initAcc) begin
        wordCnt <= '0;
        lineCnt <= '0;
      end else begin
        if (strobe.foldWord) wordCnt <= wordCnt + CNT_W'(1);
        if (strobe.emitNibble && lineCnt != LAST_LINE) lineCnt <= lineCnt + LINE_W'(1);
      end
    end
  end

  assign doneOut = (state == ST_DONE);

  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wordCnt <= CNT_W'(BLOCK_WORDS)); // R5

  AST_LINE_SATURATES: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt <= LAST_LINE); // R7

endmodule

// File: rtl/trailer_csum_dp.sv
module trailer_csum_dp
  import trailer_csum_pkg::*;
#(
  parameter int WORD_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  csStrobe_t           strobe,
  input  logic [WORD_W-1:0]   wordIn,
  output logic [WORD_W/4-1:0] nibbleOut
);

  localparam int SUM_W = WORD_W / 2;
  localparam int NIB_W = SUM_W / 2;

  logic [WORD_W-1:0] acc, accNext;
  logic [SUM_W-1:0]  csum, foldNext;
  logic [NIB_W-1:0]  lineVal;

  assign accNext  = strobe.foldWord ? (acc ^ ~wordIn) : acc;
  assign foldNext = accNext[WORD_W-1:SUM_W] ^ accNext[SUM_W-1:0];

  always_comb begin
    case (strobe.lineSel)
      LINE_W'(0): lineVal = csum[SUM_W-1:NIB_W];
      LINE_W'(1): lineVal = csum[NIB_W-1:0];
      default:    lineVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '1;
      csum      <= '0;
      nibbleOut <= '0;
    end else if (strobe.initAcc) begin
      acc       <= '1;
      nibbleOut <= '0;
    end else begin
      acc <= accNext;
      if (strobe.capture) csum <= foldNext;
      if (strobe.emitNibble) nibbleOut <= lineVal;
    end
  end

  AST_SUM_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> $stable(csum)); // R8

endmodule

// File: rtl/trailer_csum.sv
module trailer_csum
  import trailer_csum_pkg::*;
#(
  parameter int BLOCK_WORDS = 129,
  parameter int WORD_W      = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startIn,
  input  logic                wordValid,
  input  logic [WORD_W-1:0]   wordIn,
  input  logic                blockDone,
  input  logic                nibbleReq,
  output logic [WORD_W/4-1:0] nibbleOut,
  output logic                doneOut
);

  csStrobe_t strobe;

  trailer_csum_ctrl #(.BLOCK_WORDS(BLOCK_WORDS)) ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startIn   (startIn),
    .wordValid (wordValid),
    .blockDone (blockDone),
    .nibbleReq (nibbleReq),
    .strobe    (strobe),
    .doneOut   (doneOut)
  );

  trailer_csum_dp #(.WORD_W(WORD_W)) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wordIn    (wordIn),
    .nibbleOut (nibbleOut)
  );

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    startIn |=> (!doneOut && nibbleOut == '0)); // R2

  AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (doneOut && !startIn) |=> doneOut); // R8

  AST_QUIET_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    !doneOut |-> nibbleOut == '0); // R9

endmodule

// File: tb/trailer_csum_test.sv
`timescale 1ns/1ps
module trailer_csum_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startIn = 1'b0;
  logic        wordValid = 1'b0;
  logic [11:0] wordIn = '0;
  logic        blockDone = 1'b0;
  logic        nibbleReq = 1'b0;
  logic [2:0]  nibbleOut;
  logic        doneOut;

  always #2 clk = ~clk;

  trailer_csum uut (
    .clk(clk), .rstN(rstN), .startIn(startIn), .wordValid(wordValid),
    .wordIn(wordIn), .blockDone(blockDone), .nibbleReq(nibbleReq),
    .nibbleOut(nibbleOut), .doneOut(doneOut)
  );

  int errs = 0;
  int checks = 0;
  bit finished = 0;
  logic [11:0] expAcc = 12'hFFF;
  logic [2:0]  expQ[$];
  string       tagQ[$];
  logic        reqSeen = 1'b0;

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [5:0] foldSum(logic [11:0] a);
    return a[11:6] ^ a[5:0];
  endfunction

  // monitor: compare each requested line against the scoreboard
  always @(posedge clk) reqSeen <= nibbleReq;
  always @(negedge clk) begin
    if (reqSeen) begin
      if (expQ.size() == 0) begin
        check(0, "R7 unexpected line", nibbleOut, 0);
      end else begin
        logic [2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(nibbleOut == e, t, nibbleOut, e);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic doStart();
    startIn = 1'b1;
    step();
    startIn = 1'b0;
    expAcc = 12'hFFF;
    check(doneOut == 1'b0 && nibbleOut == 3'd0, "R2 start clears", {doneOut, nibbleOut}, 0);
  endtask

  task automatic putWord(logic [11:0] w, bit withDone, bit accepted);
    wordValid = 1'b1;
    wordIn = w;
    blockDone = withDone;
    step();
    wordValid = 1'b0;
    blockDone = 1'b0;
    if (accepted) expAcc = expAcc ^ ~w;
  endtask

  task automatic askLine(logic [2:0] e, string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    nibbleReq = 1'b1;
    step();
    nibbleReq = 1'b0;
  endtask

  task automatic expectSum(string tag);
    logic [5:0] s;
    s = foldSum(expAcc);
    askLine(s[5:3], {tag, " R4 R7 high"});
    askLine(s[2:0], {tag, " R4 R7 low"});
    askLine(3'd0, {tag, " R7 late line"});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    check(doneOut == 1'b0, "R1 reset done", doneOut, 0);
    check(nibbleOut == 3'd0, "R1 reset nibble", nibbleOut, 0);
    rstN = 1'b1;
    step();

    // R9: activity before any start
    askLine(3'd0, "R9 request before start");
    putWord(12'h5A5, 1'b0, 1'b0);
    check(doneOut == 1'b0, "R9 word before start", doneOut, 0);

    // R5: full-length block closes on its own
    doStart();
    for (int i = 0; i < 129; i++) begin
      if (i == 128) check(doneOut == 1'b0, "R5 open before last word", doneOut, 0);
      putWord(12'((i * 37) + 5), 1'b0, 1'b1);
    end
    check(doneOut == 1'b1, "R5 done after last word", doneOut, 1);
    // R8: traffic after completion is ignored
    putWord(12'h123, 1'b0, 1'b0);
    putWord(12'h456, 1'b1, 1'b0);
    check(doneOut == 1'b1, "R8 done held", doneOut, 1);
    expectSum("R5 full block");
    askLine(3'd0, "R7 further late line");

    // R3 R4: single known words, hand values
    doStart();
    putWord(12'hFC0, 1'b1, 1'b1);
    askLine(3'd7, "R3 word FC0 high");
    askLine(3'd7, "R3 word FC0 low");
    doStart();
    putWord(12'h7C1, 1'b1, 1'b1);
    askLine(3'd3, "R3 word 7C1 high");
    askLine(3'd6, "R3 word 7C1 low");

    // R2: word alongside start is discarded; R6 early close with word
    startIn = 1'b1;
    wordValid = 1'b1;
    wordIn = 12'hABC;
    step();
    startIn = 1'b0;
    wordValid = 1'b0;
    expAcc = 12'hFFF;
    check(doneOut == 1'b0, "R2 start with word", doneOut, 0);
    for (int i = 0; i < 4; i++) putWord(12'(12'h111 * (i + 1)), 1'b0, 1'b1);
    askLine(3'd0, "R9 request mid block");
    putWord(12'h9E7, 1'b1, 1'b1);
    check(doneOut == 1'b1, "R6 early close", doneOut, 1);
    expectSum("R6 five words");

    // R6: close with no words
    doStart();
    blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    check(doneOut == 1'b1, "R6 empty close", doneOut, 1);
    askLine(3'd0, "R6 empty high");
    askLine(3'd0, "R6 empty low");

    // R2: restart in the middle of a block
    doStart();
    putWord(12'hFFF, 1'b0, 1'b1);
    putWord(12'h321, 1'b0, 1'b1);
    doStart();
    putWord(12'h0F0, 1'b0, 1'b1);
    putWord(12'h555, 1'b0, 1'b1);
    blockDone = 1'b1;
    step();
    blockDone = 1'b0;
    expectSum("R2 restart");

    repeat (3) step();
    check(expQ.size() == 0, "R7 scoreboard drained", expQ.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule